// File: doc/BRIEF.md
# Wave-front micro-tile issue sequencer

This block drives the coordinate input of a deeply pipelined tile datapath. After a start request it hands out one micro-tile coordinate per cycle for a pass made of a configurable number of macro-tiles. A macro-tile is one parallel wave-front. Along the pass direction it is one micro-tile thick. Across the parallel dimensions its extent is set by per-dimension widths. Within a front the coordinates are visited lexicographically. Fronts follow one another in order, so the pass is swept front-major.

The datapath needs the results of one front to have drained before the next front reads them. For this reason the block refuses any configuration whose front volume is smaller than the datapath pipeline depth parameter. Only full tiles are issued. Partial boundary tiles are handled outside. A stall input freezes issue without losing position. First and last pulses mark the edges of each macro-tile for buffer control, and a done pulse closes the pass.

Top module: `wfront_seq`

## Requirements
- R1: After reset, issue_valid, done and cfg_err are all 0.
- R2: A start sampled at a clock edge while idle, with a legal configuration, latches the widths and the macro-tile count. The first issue is offered in the following cycle with every coordinate 0 and macro_idx 0.
- R3: Coordinates advance in lexicographic order. Field k of width_in and coord occupies bits [k*CW +: CW]. Field 0 changes fastest and the highest field slowest. Each field runs from 0 to its width minus 1. One coordinate is issued per unstalled cycle.
- R4: After the product of all widths (the volume V) issues, macro_idx increments and the coordinates restart at 0. A pass issues exactly V times macro_count micro-tiles.
- R5: first_of_macro is high exactly on the first issue of each macro-tile. last_of_macro is high exactly on its last issue. Both are low whenever issue_valid is low.
- R6: done is high for exactly one cycle, the cycle after the final issue of the pass. The block is then idle, with no further issues.
- R7: A start is refused when V < DEPTH, when any width is 0, or when macro_count is 0. In that case cfg_err rises in the next cycle and no issue occurs. The next accepted start clears cfg_err.
- R8: While stall is high, issue_valid is 0 and the coordinates and macro_idx hold their values. Issuing resumes at the held position.
- R9: start, width_in and macro_count are ignored while a pass is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new pass (used only when idle) |
| stall | input | 1 | Hold issue for this cycle |
| width_in | input | NPAR*CW | Per-dimension front widths, field k at [k*CW +: CW] |
| macro_count | input | MW | Number of macro-tiles in the pass |
| issue_valid | output | 1 | A micro-tile is issued this cycle |
| coord | output | NPAR*CW | Micro-tile coordinate within the front |
| macro_idx | output | MW | Index of the current macro-tile (front) |
| first_of_macro | output | 1 | First issue of a macro-tile |
| last_of_macro | output | 1 | Last issue of a macro-tile |
| done | output | 1 | One-cycle pulse after the final issue |
| cfg_err | output | 1 | Last start request was refused |

## Verification
The issue outputs are combinational from the registered position and the current stall. The first issue is therefore due in the cycle right after the edge that samples start. Each later issue, or its suppression, is visible in the same cycle that stall is driven. done and cfg_err come from registers and are due one cycle after the edge that caused them: the final issue, or the refused start. The bench changes inputs just after a rising edge and compares at the falling edge of the same cycle. A bench model advances only on cycles it expects to issue, so every comparison refers to the exact cycle in which the result is due.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
    typedef struct packed {
        logic run;
        logic err;
        logic done;
    } wfs_flags_t;
endpackage

// File: rtl/wfront_digit.sv
module wfront_digit #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] val,
    output logic         wrap
);
    logic [W-1:0] val_d, val_q;

    assign wrap = inc && (val_q == limit - W'(1));
    assign val  = val_q;

    always_comb begin
        val_d = val_q;
        if (clr)
            val_d = '0;
        else if (wrap)
            val_d = '0;
        else if (inc)
            val_d = val_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end
endmodule

// File: rtl/wfront_cfg_chk.sv
module wfront_cfg_chk #(
    parameter int NPAR  = 2,
    parameter int CW    = 4,
    parameter int MW    = 4,
    parameter int DEPTH = 6
) (
    input  logic [NPAR*CW-1:0] width_in,
    input  logic [MW-1:0]      macro_count,
    output logic               ok_o
);
    localparam int PW = NPAR * CW + 1;
    logic [PW-1:0] vol;

    always_comb begin
        vol = PW'(1);
        for (int k = 0; k < NPAR; k++)
            vol = vol * PW'(width_in[k*CW +: CW]);
        ok_o = (vol >= PW'(DEPTH)) && (macro_count != '0);
    end
endmodule

// File: rtl/wfront_seq.sv
module wfront_seq
    import wfs_pkg::*;
#(
    parameter int NPAR  = 2,
    parameter int CW    = 4,
    parameter int MW    = 4,
    parameter int DEPTH = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               stall,
    input  logic [NPAR*CW-1:0] width_in,
    input  logic [MW-1:0]      macro_count,
    output logic               issue_valid,
    output logic [NPAR*CW-1:0] coord,
    output logic [MW-1:0]      macro_idx,
    output logic               first_of_macro,
    output logic               last_of_macro,
    output logic               done,
    output logic               cfg_err
);
    localparam int CFGW = NPAR * CW;

    typedef struct packed {
        wfs_flags_t      f;
        logic [CFGW-1:0] wid;
        logic [MW-1:0]   nm;
    } st_t;

    st_t s_d, s_q;

    logic            cfg_ok;
    logic            adv;
    logic            accept;
    logic            load;
    logic [NPAR:0]   inc;
    logic [NPAR-1:0] wrap;
    logic [NPAR-1:0] zero;
    logic            m_wrap;

    wfront_cfg_chk #(.NPAR(NPAR), .CW(CW), .MW(MW), .DEPTH(DEPTH)) u_cfg (
        .width_in    (width_in),
        .macro_count (macro_count),
        .ok_o        (cfg_ok)
    );

    assign adv    = s_q.f.run && !stall;
    assign accept = !s_q.f.run && start;
    assign load   = accept && cfg_ok;
    assign inc[0] = adv;

    // one digit per parallel dimension; field 0 is the fastest
    for (genvar k = 0; k < NPAR; k++) begin : g_dim
        wfront_digit #(.W(CW)) u_dig (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (load),
            .inc   (inc[k]),
            .limit (s_q.wid[k*CW +: CW]),
            .val   (coord[k*CW +: CW]),
            .wrap  (wrap[k])
        );
        assign inc[k+1] = wrap[k];
        assign zero[k]  = (coord[k*CW +: CW] == '0);
    end

    wfront_digit #(.W(MW)) u_macro (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .inc   (inc[NPAR]),
        .limit (s_q.nm),
        .val   (macro_idx),
        .wrap  (m_wrap)
    );

    always_comb begin
        s_d        = s_q;
        s_d.f.done = 1'b0;
        if (accept) begin
            if (cfg_ok) begin
                s_d.f.run = 1'b1;
                s_d.f.err = 1'b0;
                s_d.wid   = width_in;
                s_d.nm    = macro_count;
            end else begin
                s_d.f.err = 1'b1;
            end
        end
        if (m_wrap) begin
            s_d.f.run  = 1'b0;
            s_d.f.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign issue_valid    = adv;
    assign first_of_macro = adv && (&zero);
    assign last_of_macro  = adv && wrap[NPAR-1];
    assign done           = s_q.f.done;
    assign cfg_err        = s_q.f.err;
endmodule

// File: rtl/wfront_seq_chk.sv
module wfront_seq_chk #(
    parameter int NPAR = 2,
    parameter int CW   = 4,
    parameter int MW   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stall,
    input logic               run,
    input logic               issue_valid,
    input logic [NPAR*CW-1:0] coord,
    input logic [NPAR*CW-1:0] wid,
    input logic [MW-1:0]      macro_idx,
    input logic [MW-1:0]      nm,
    input logic               first_of_macro,
    input logic               last_of_macro,
    input logic               done,
    input logic               cfg_err
);
    for (genvar k = 0; k < NPAR; k++) begin : g_rng
        AST_COORD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid |-> (coord[k*CW +: CW] < wid[k*CW +: CW])); // R3
    end

    AST_MACRO_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (macro_idx < nm)); // R4

    AST_MARKS_NEED_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (first_of_macro || last_of_macro) |-> issue_valid); // R5

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(last_of_macro) && ($past(macro_idx) == nm - MW'(1)))); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_ERR_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !issue_valid); // R7

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && stall) |=> ($stable(coord) && $stable(macro_idx))); // R8

    AST_STALL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !issue_valid); // R8
endmodule

bind wfront_seq wfront_seq_chk #(.NPAR(NPAR), .CW(CW), .MW(MW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .stall          (stall),
    .run            (s_q.f.run),
    .issue_valid    (issue_valid),
    .coord          (coord),
    .wid            (s_q.wid),
    .macro_idx      (macro_idx),
    .nm             (s_q.nm),
    .first_of_macro (first_of_macro),
    .last_of_macro  (last_of_macro),
    .done           (done),
    .cfg_err        (cfg_err)
);

// File: tb/sim_wfront_seq.sv
`timescale 1ns/1ps
module sim_wfront_seq;
    localparam int NPAR  = 2;
    localparam int CW    = 4;
    localparam int MW    = 4;
    localparam int DEPTH = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               stall = 1'b0;
    logic [NPAR*CW-1:0] width_in = '0;
    logic [MW-1:0]      macro_count = '0;
    logic               issue_valid;
    logic [NPAR*CW-1:0] coord;
    logic [MW-1:0]      macro_idx;
    logic               first_of_macro;
    logic               last_of_macro;
    logic               done;
    logic               cfg_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wfront_seq #(.NPAR(NPAR), .CW(CW), .MW(MW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .stall(stall),
        .width_in(width_in), .macro_count(macro_count),
        .issue_valid(issue_valid), .coord(coord), .macro_idx(macro_idx),
        .first_of_macro(first_of_macro), .last_of_macro(last_of_macro),
        .done(done), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_coord(input int a, input int b);
        return (a << CW) | b;
    endfunction

    function automatic bit cfg_legal(input int wa, input int wb, input int nm);
        return (wa * wb >= DEPTH) && (nm != 0);
    endfunction

    // illegal configuration: expect refusal
    task automatic bad_pass(input int wa, input int wb, input int nm);
        @(posedge clk); #1;
        width_in = {CW'(wa), CW'(wb)}; macro_count = MW'(nm); start = 1'b1; stall = 1'b0;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R7", "cfg_err after refused start", int'(cfg_err), 1);
        for (int i = 0; i < 4; i++) begin
            chk(issue_valid == 1'b0, "R7", "no issue after refusal", int'(issue_valid), 0);
            @(negedge clk);
        end
    endtask

    // legal pass with random stall and ignored input noise
    task automatic good_pass(input int wa, input int wb, input int nm, input int stall_pct);
        int ea = 0, eb = 0, em = 0, left, n = 0, guard = 0;
        left = wa * wb * nm;
        @(posedge clk); #1;
        width_in = {CW'(wa), CW'(wb)}; macro_count = MW'(nm); start = 1'b1; stall = 1'b0;
        @(posedge clk); #1;
        start = 1'b0;
        while (left > 0 && guard < 5000) begin
            guard++;
            stall = (($urandom % 100) < stall_pct);
            if (n > 0 && ($urandom % 8) == 0) begin
                start = 1'b1;                                   // R9 noise
                width_in = NPAR*CW'($urandom);
                macro_count = MW'($urandom);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (n == 0)
                chk(cfg_err == 1'b0, "R7", "cfg_err cleared by accepted start", int'(cfg_err), 0);
            chk(done == 1'b0, "R6", "done during pass", int'(done), 0);
            if (stall) begin
                chk(issue_valid == 1'b0, "R8", "issue while stalled", int'(issue_valid), 0);
            end else begin
                chk(issue_valid == 1'b1, n == 0 ? "R2" : "R9", "issue_valid", int'(issue_valid), 1);
                chk(int'(coord) == exp_coord(ea, eb), n == 0 ? "R2" : "R3", "coord",
                    int'(coord), exp_coord(ea, eb));
                chk(int'(macro_idx) == em, "R4", "macro_idx", int'(macro_idx), em);
                chk(first_of_macro == (ea == 0 && eb == 0), "R5", "first_of_macro",
                    int'(first_of_macro), int'(ea == 0 && eb == 0));
                chk(last_of_macro == (ea == wa - 1 && eb == wb - 1), "R5", "last_of_macro",
                    int'(last_of_macro), int'(ea == wa - 1 && eb == wb - 1));
                eb++;
                if (eb == wb) begin
                    eb = 0; ea++;
                    if (ea == wa) begin ea = 0; em++; end
                end
                left--;
                n++;
            end
            @(posedge clk); #1;
        end
        start = 1'b0; stall = 1'b0;
        @(negedge clk);
        chk(done == 1'b1, "R6", "done after final issue", int'(done), 1);
        chk(issue_valid == 1'b0, "R4", "no issue past V*count", int'(issue_valid), 0);
        @(negedge clk);
        chk(done == 1'b0, "R6", "done pulse width", int'(done), 0);
        chk(issue_valid == 1'b0, "R6", "idle after done", int'(issue_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int wa, wb, nm;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(issue_valid == 1'b0, "R1", "issue_valid in reset", int'(issue_valid), 0);
        chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
        chk(cfg_err == 1'b0, "R1", "cfg_err in reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(issue_valid == 1'b0, "R1", "issue_valid after reset", int'(issue_valid), 0);

        good_pass(2, 3, 3, 0);      // V equals DEPTH exactly
        good_pass(3, 4, 2, 30);     // stalls
        good_pass(1, 6, 2, 0);      // slow dimension of width 1
        bad_pass(2, 2, 1);          // V below DEPTH
        good_pass(6, 1, 1, 20);     // clears error; fast dimension of width 1
        bad_pass(0, 8, 1);          // zero width
        bad_pass(3, 3, 0);          // zero macro count
        good_pass(15, 15, 1, 10);   // largest widths
        for (int p = 0; p < 8; p++) begin
            do begin
                wa = 1 + int'($urandom % 5);
                wb = 1 + int'($urandom % 5);
                nm = 1 + int'($urandom % 4);
            end while (!cfg_legal(wa, wb, nm));
            good_pass(wa, wb, nm, int'($urandom % 40));
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule